// File: doc/BRIEF.md
# Dual-Width Flag Integer ALU

This block is the integer execute stage of a 64-bit core. Each accepted operation combines operand A with either operand B or a sign-extended immediate and produces a 64-bit result. It also keeps an 8-bit condition-code register. That register carries one group of carry, overflow, zero and negative flags for the low 32 bits of the result and a second group for the full 64 bits. Both groups are computed from the same operation in the same cycle. The operations are add, subtract, their carry-in forms, six bitwise logical operations and a set-upper-bits operation that loads a 22-bit constant.

Operations enter on a valid/ready stream and leave on a second one. The block holds one operation in its output register. The input is ready whenever that register is empty or is being drained in the same cycle. The result appears one cycle after acceptance and stays frozen while the consumer holds ready low.

The condition-code register changes at the edge that accepts an operation whose flag-update input is set. Its value therefore always describes the most recently accepted flag-setting operation. The carry-in forms read the 32-bit carry bit of this register.

Top module: `dual_flag_alu`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_cc` is 0x00. The `out_cc` bits are: bit 0 low-half carry, bit 1 low-half overflow, bit 2 low-half zero, bit 3 low-half negative, bit 4 full carry, bit 5 full overflow, bit 6 full zero, bit 7 full negative.
- R2: For every flag-setting operation other than set-upper (code 10), bit 3 equals result bit 31 and bit 2 is set exactly when result bits 31:0 are all zero. Bit 7 equals result bit 63 and bit 6 is set exactly when all 64 result bits are zero.
- R3: Add (code 0) returns A+B. Bit 0 is the carry out of bit 31 and bit 4 is the carry out of bit 63. Overflow at width N is set when A[N-1] equals B[N-1] and the result bit N-1 differs from A[N-1].
- R4: Subtract (code 2) returns A-B, computed as A + ~B + 1. Each carry bit is the inverse of the carry out of that sum at its width, so it acts as a borrow. Each overflow bit uses the R3 rule with ~B in place of B.
- R5: Add-with-carry (code 1) adds the stored bit 0 as carry-in. Subtract-with-borrow (code 3) computes A + ~B + (1 - stored bit 0). Their flags follow R3 and R4 respectively.
- R6: The logical codes are 4 AND, 5 OR, 6 XOR, 7 A AND NOT B, 8 A OR NOT B and 9 XNOR. When they set flags, bits 0, 1, 4 and 5 are cleared.
- R7: An operation accepted with `in_set_cc` low leaves `out_cc` unchanged, but its result is still delivered.
- R8: Set-upper (code 10) returns `in_imm[21:0]` placed in result bits 31:10, with all other bits zero. It never changes `out_cc`, and it ignores operand A, operand B and the immediate-select input.
- R9: Set-upper with `in_dest` 0 and an immediate of 0 is a no-op and delivers `out_wr` 0. Every other accepted operation delivers `out_wr` 1, with `out_dest` equal to its `in_dest`.
- R10: When `in_use_imm` is 1, operand B is `in_imm` sign-extended to 64 bits. The width depends on `in_imm_form`: 0 gives 13 bits, 1 gives 11 bits, 2 gives 10 bits and 3 gives 13 bits. Immediate bits above the selected width have no effect.
- R11: `in_ready` is 1 when `out_valid` is 0 or `out_ready` is 1. While `out_valid` is 1 and `out_ready` is 0, all outputs hold their values and no input is accepted.
- R12: A result is presented on the output one cycle after its operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_op | input | 4 | Operation code |
| in_set_cc | input | 1 | Update the condition codes with this operation |
| in_use_imm | input | 1 | Take operand B from the immediate |
| in_imm_form | input | 2 | Immediate sign-extension width select |
| in_imm | input | 22 | Immediate field |
| in_dest | input | 5 | Destination index, carried to the output |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B (register form) |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Result |
| out_dest | output | 5 | Destination index of the result |
| out_wr | output | 1 | Result must be written (0 for the no-op form) |
| out_cc | output | 8 | Condition-code register |

## Verification
The properties assume that `in_op` always holds a defined code (0 to 10) while `in_valid` is high. They also assume that reset is held across at least one clock edge before the first operation. The stimulus issues only the listed codes and raises `in_valid` only after reset is released. The stall properties assume that the consumer may hold `out_ready` low for any number of cycles. The bench therefore holds it low for several cycles while it offers a second operation, to show that the second operation waits.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDC  = 4'd1,
    OP_SUB   = 4'd2,
    OP_SUBC  = 4'd3,
    OP_AND   = 4'd4,
    OP_OR    = 4'd5,
    OP_XOR   = 4'd6,
    OP_ANDN  = 4'd7,
    OP_ORN   = 4'd8,
    OP_XNOR  = 4'd9,
    OP_SETUP = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    KIND_ADD   = 2'd0,
    KIND_SUB   = 2'd1,
    KIND_LOGIC = 2'd2
  } flag_kind_e;

  typedef enum logic [1:0] {
    IMM_W13   = 2'd0,
    IMM_W11   = 2'd1,
    IMM_W10   = 2'd2,
    IMM_W13B  = 2'd3
  } imm_form_e;

  localparam int CC_BITS = 8;

endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
  parameter int DW   = 64,
  parameter int WMAX = 13,
  parameter int WMID = 11,
  parameter int WMIN = 10
) (
  input  logic [WMAX-1:0] raw,
  input  logic [1:0]      form,
  output logic [DW-1:0]   value
);
  import alu_pkg::*;

  logic [DW-1:0] ext_max, ext_mid, ext_min;

  assign ext_max = {{(DW-WMAX){raw[WMAX-1]}}, raw[WMAX-1:0]};
  assign ext_mid = {{(DW-WMID){raw[WMID-1]}}, raw[WMID-1:0]};
  assign ext_min = {{(DW-WMIN){raw[WMIN-1]}}, raw[WMIN-1:0]};

  always_comb begin
    case (imm_form_e'(form))
      IMM_W11: value = ext_mid;
      IMM_W10: value = ext_min;
      default: value = ext_max;
    endcase
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          c_half,
  output logic          c_full
);
  localparam int HW = DW / 2;

  logic [HW:0] low_sum;
  logic [DW:0] full_sum;

  assign low_sum  = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cin};
  assign full_sum = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};

  assign sum    = full_sum[DW-1:0];
  assign c_half = low_sum[HW];
  assign c_full = full_sum[DW];
endmodule

// File: rtl/alu_ccgen.sv
module alu_ccgen #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] res,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          c_half,
  input  logic          c_full,
  input  logic [1:0]    kind,
  output logic [7:0]    cc
);
  import alu_pkg::*;

  localparam int HW = DW / 2;

  logic [1:0] carry, ovf, zero, neg;

  // index 0: low half, index 1: full width
  assign zero[0] = (res[HW-1:0] == '0);
  assign zero[1] = (res == '0);
  assign neg[0]  = res[HW-1];
  assign neg[1]  = res[DW-1];

  always_comb begin
    case (flag_kind_e'(kind))
      KIND_ADD: begin
        carry = {c_full, c_half};
        ovf[0] = (opa[HW-1] == opb[HW-1]) && (res[HW-1] != opa[HW-1]);
        ovf[1] = (opa[DW-1] == opb[DW-1]) && (res[DW-1] != opa[DW-1]);
      end
      KIND_SUB: begin
        carry = {~c_full, ~c_half};
        ovf[0] = (opa[HW-1] == opb[HW-1]) && (res[HW-1] != opa[HW-1]);
        ovf[1] = (opa[DW-1] == opb[DW-1]) && (res[DW-1] != opa[DW-1]);
      end
      default: begin
        carry = 2'b00;
        ovf   = 2'b00;
      end
    endcase
  end

  assign cc = {neg[1], zero[1], ovf[1], carry[1], neg[0], zero[0], ovf[0], carry[0]};
endmodule

// File: rtl/dual_flag_alu.sv
module dual_flag_alu #(
  parameter int DW    = 64,
  parameter int IMMW  = 22,
  parameter int DESTW = 5,
  parameter int SIMMW = 13,
  parameter int SHIFT = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_op,
  input  logic             in_set_cc,
  input  logic             in_use_imm,
  input  logic [1:0]       in_imm_form,
  input  logic [IMMW-1:0]  in_imm,
  input  logic [DESTW-1:0] in_dest,
  input  logic [DW-1:0]    in_a,
  input  logic [DW-1:0]    in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_result,
  output logic [DESTW-1:0] out_dest,
  output logic             out_wr,
  output logic [7:0]       out_cc
);
  import alu_pkg::*;

  localparam int UPPER_PAD = DW - IMMW - SHIFT;

  alu_op_e       op;
  logic [DW-1:0] imm_val, opb_sel, opb_eff, sum;
  logic          cin, c_half, c_full, is_sub;
  logic [1:0]    kind;
  logic [DW-1:0] result_d;
  logic [7:0]    cc_calc;
  logic          accept, is_setup, is_nop;

  logic [DW-1:0]    res_q;
  logic [DESTW-1:0] dest_q;
  logic             wr_q, valid_q;
  logic [7:0]       cc_q;

  assign op = alu_op_e'(in_op);

  alu_imm_ext #(.DW(DW), .WMAX(SIMMW), .WMID(11), .WMIN(10)) u_imm (
    .raw   (in_imm[SIMMW-1:0]),
    .form  (in_imm_form),
    .value (imm_val)
  );

  assign opb_sel = in_use_imm ? imm_val : in_b;
  assign is_sub  = (op == OP_SUB) || (op == OP_SUBC);
  assign opb_eff = is_sub ? ~opb_sel : opb_sel;

  always_comb begin
    case (op)
      OP_ADDC: cin = cc_q[0];
      OP_SUB:  cin = 1'b1;
      OP_SUBC: cin = ~cc_q[0];
      default: cin = 1'b0;
    endcase
  end

  alu_adder #(.DW(DW)) u_add (
    .a      (in_a),
    .b      (opb_eff),
    .cin    (cin),
    .sum    (sum),
    .c_half (c_half),
    .c_full (c_full)
  );

  always_comb begin
    kind = KIND_LOGIC;
    case (op)
      OP_ADD, OP_ADDC: begin kind = KIND_ADD; result_d = sum; end
      OP_SUB, OP_SUBC: begin kind = KIND_SUB; result_d = sum; end
      OP_AND:   result_d = in_a & opb_sel;
      OP_OR:    result_d = in_a | opb_sel;
      OP_XOR:   result_d = in_a ^ opb_sel;
      OP_ANDN:  result_d = in_a & ~opb_sel;
      OP_ORN:   result_d = in_a | ~opb_sel;
      OP_XNOR:  result_d = ~(in_a ^ opb_sel);
      OP_SETUP: result_d = {{UPPER_PAD{1'b0}}, in_imm, {SHIFT{1'b0}}};
      default:  result_d = '0;
    endcase
  end

  alu_ccgen #(.DW(DW)) u_cc (
    .res    (result_d),
    .opa    (in_a),
    .opb    (opb_eff),
    .c_half (c_half),
    .c_full (c_full),
    .kind   (kind),
    .cc     (cc_calc)
  );

  assign is_setup = (op == OP_SETUP);
  assign is_nop   = is_setup && (in_dest == '0) && (in_imm == '0);
  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      dest_q  <= '0;
      wr_q    <= 1'b0;
      cc_q    <= '0;
    end else begin
      if (accept) begin
        valid_q <= 1'b1;
        res_q   <= result_d;
        dest_q  <= in_dest;
        wr_q    <= !is_nop;
        if (in_set_cc && !is_setup) cc_q <= cc_calc;
      end else if (out_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_result = res_q;
  assign out_dest   = dest_q;
  assign out_wr     = wr_q;
  assign out_cc     = cc_q;
endmodule

// File: rtl/dual_flag_alu_chk.sv
module dual_flag_alu_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [3:0]  in_op,
  input logic        in_set_cc,
  input logic [21:0] in_imm,
  input logic [4:0]  in_dest,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_result,
  input logic        out_wr,
  input logic [7:0]  out_cc
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_cc)));

  assert_stall_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_latency_R12: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);

  assert_keep_cc_R7: assert property (@(posedge clk) disable iff (rst)
    (acc && !in_set_cc) |=> $stable(out_cc));

  assert_setup_cc_R8: assert property (@(posedge clk) disable iff (rst)
    (acc && in_op == 4'd10) |=> ($stable(out_cc) && out_result[9:0] == 10'd0
                                 && out_result[63:32] == 32'd0));

  assert_logic_cv_R6: assert property (@(posedge clk) disable iff (rst)
    (acc && in_set_cc && in_op >= 4'd4 && in_op <= 4'd9)
      |=> (out_cc[1:0] == 2'b00 && out_cc[5:4] == 2'b00));

  assert_zn_R2: assert property (@(posedge clk) disable iff (rst)
    (acc && in_set_cc && in_op != 4'd10)
      |=> (out_cc[3] == out_result[31] && out_cc[2] == (out_result[31:0] == 32'd0)
           && out_cc[7] == out_result[63] && out_cc[6] == (out_result == 64'd0)));

  assert_nop_R9: assert property (@(posedge clk) disable iff (rst)
    acc |=> (out_wr == !($past(in_op) == 4'd10 && $past(in_dest) == 5'd0
                         && $past(in_imm) == 22'd0)));
endmodule

bind dual_flag_alu dual_flag_alu_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
  .in_set_cc(in_set_cc), .in_imm(in_imm), .in_dest(in_dest), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result), .out_wr(out_wr), .out_cc(out_cc)
);

// File: tb/sim_dual_flag_alu.sv
module sim_dual_flag_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_set_cc = 1'b0, in_use_imm = 1'b0, out_ready = 1'b1;
  logic [3:0]  in_op = 4'd0;
  logic [1:0]  in_imm_form = 2'd0;
  logic [21:0] in_imm = '0;
  logic [4:0]  in_dest = '0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        in_ready, out_valid, out_wr;
  logic [63:0] out_result;
  logic [4:0]  out_dest;
  logic [7:0]  out_cc;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] exp_cc = 8'h00;

  always #2 clk = ~clk;

  dual_flag_alu u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_set_cc(in_set_cc), .in_use_imm(in_use_imm), .in_imm_form(in_imm_form),
    .in_imm(in_imm), .in_dest(in_dest), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_dest(out_dest), .out_wr(out_wr), .out_cc(out_cc)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // reference from the requirements: returns {cc, result}
  function automatic logic [71:0] model(input logic [3:0] op, input logic [63:0] a,
                                        input logic [63:0] b, input logic c0);
    logic [63:0] bb, r;
    logic [32:0] lo;
    logic [64:0] fu;
    logic ci, sub, lg;
    logic [7:0] f;
    sub = (op == 4'd2 || op == 4'd3);
    bb  = sub ? ~b : b;
    ci  = (op == 4'd1) ? c0 : (op == 4'd2) ? 1'b1 : (op == 4'd3) ? !c0 : 1'b0;
    lg  = (op >= 4'd4);
    lo  = {1'b0, a[31:0]} + {1'b0, bb[31:0]} + {32'd0, ci};
    fu  = {1'b0, a} + {1'b0, bb} + {64'd0, ci};
    case (op)
      4'd4: r = a & b;
      4'd5: r = a | b;
      4'd6: r = a ^ b;
      4'd7: r = a & ~b;
      4'd8: r = a | ~b;
      4'd9: r = ~(a ^ b);
      default: r = fu[63:0];
    endcase
    f[0] = lg ? 1'b0 : (lo[32] ^ sub);
    f[4] = lg ? 1'b0 : (fu[64] ^ sub);
    f[1] = lg ? 1'b0 : (a[31] == bb[31]) && (r[31] != a[31]);
    f[5] = lg ? 1'b0 : (a[63] == bb[63]) && (r[63] != a[63]);
    f[2] = (r[31:0] == 32'd0);
    f[3] = r[31];
    f[6] = (r == 64'd0);
    f[7] = r[63];
    return {f, r};
  endfunction

  task automatic issue(input logic [3:0] op, input logic setcc, input logic [63:0] a,
                       input logic [63:0] b, input logic [4:0] dest);
    @(negedge clk);
    in_op = op; in_set_cc = setcc; in_use_imm = 1'b0; in_a = a; in_b = b;
    in_dest = dest; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic arith(input string req, input logic [3:0] op, input logic setcc,
                       input logic [63:0] a, input logic [63:0] b);
    logic [71:0] m;
    m = model(op, a, b, exp_cc[0]);
    issue(op, setcc, a, b, 5'd7);
    if (setcc) exp_cc = m[71:64];
    chk(req, out_result, m[63:0]);
    chk(req, {56'd0, out_cc}, {56'd0, exp_cc});
    chk({req, " valid"}, {63'd0, out_valid}, 64'd1);
  endtask

  task automatic t_reset;
    chk("R1 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R1 reset cc", {56'd0, out_cc}, 64'd0);
    chk("R11 ready idle", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_add;
    arith("R3 add small", 4'd0, 1'b1, 64'd1, 64'd2);
    chk("R1 add cc lit", {56'd0, out_cc}, 64'h00);
    arith("R3 add c32", 4'd0, 1'b1, 64'hFFFF_FFFF, 64'd1);
    chk("R2 add c32 cc lit", {56'd0, out_cc}, 64'h05);
    arith("R3 add v32", 4'd0, 1'b1, 64'h7FFF_FFFF, 64'd1);
    chk("R3 add v32 cc lit", {56'd0, out_cc}, 64'h0A);
    arith("R3 add wrap", 4'd0, 1'b1, '1, 64'd1);
    chk("R2 add wrap cc lit", {56'd0, out_cc}, 64'h55);
    arith("R3 add v64", 4'd0, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1);
    chk("R3 add v64 cc lit", {56'd0, out_cc}, 64'hA5);
    chk("R9 dest", {59'd0, out_dest}, 64'd7);
    chk("R9 wr", {63'd0, out_wr}, 64'd1);
  endtask

  task automatic t_sub;
    arith("R4 sub plain", 4'd2, 1'b1, 64'd5, 64'd3);
    chk("R4 sub cc lit", {56'd0, out_cc}, 64'h00);
    arith("R4 sub borrow", 4'd2, 1'b1, 64'd3, 64'd5);
    chk("R4 sub borrow cc lit", {56'd0, out_cc}, 64'h99);
    arith("R4 sub v64", 4'd2, 1'b1, 64'h8000_0000_0000_0000, 64'd1);
    chk("R4 sub v64 cc lit", {56'd0, out_cc}, 64'h29);
    arith("R4 sub zero", 4'd2, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0);
    chk("R2 sub zero cc lit", {56'd0, out_cc}, 64'h44);
  endtask

  task automatic t_carry_in;
    arith("R5 set c", 4'd0, 1'b1, 64'hFFFF_FFFF, 64'd1);
    arith("R5 addc c1", 4'd1, 1'b1, 64'd1, 64'd1);
    chk("R5 addc c1 lit", out_result, 64'd3);
    arith("R5 addc c0", 4'd1, 1'b1, 64'd1, 64'd1);
    chk("R5 addc c0 lit", out_result, 64'd2);
    arith("R5 make borrow", 4'd2, 1'b1, 64'd3, 64'd5);
    arith("R5 subc b1", 4'd3, 1'b1, 64'd10, 64'd3);
    chk("R5 subc b1 lit", out_result, 64'd6);
    arith("R5 subc b0", 4'd3, 1'b1, 64'd10, 64'd3);
    chk("R5 subc b0 lit", out_result, 64'd7);
  endtask

  task automatic t_logic;
    for (int k = 4; k <= 9; k++) begin
      arith("R6 prime carries", 4'd0, 1'b1, '1, 64'd1);
      arith("R6 logic op", k[3:0], 1'b1, 64'hF0F0_0000_FFFF_0F0F, 64'h0FF0_FFFF_00FF_8F00);
    end
    arith("R6 xor zero", 4'd6, 1'b1, 64'hDEAD, 64'hDEAD);
    chk("R6 xor zero cc lit", {56'd0, out_cc}, 64'h44);
  endtask

  task automatic t_nocc;
    arith("R7 prime", 4'd2, 1'b1, 64'd3, 64'd5);
    arith("R7 add no cc", 4'd0, 1'b0, '1, 64'd1);
    chk("R7 cc kept lit", {56'd0, out_cc}, 64'h99);
    arith("R7 logic no cc", 4'd4, 1'b0, 64'd0, 64'd0);
  endtask

  task automatic setup(input string req, input logic [21:0] imm, input logic [4:0] dest,
                       input logic [63:0] exp_r, input logic exp_wr);
    @(negedge clk);
    in_op = 4'd10; in_set_cc = 1'b1; in_use_imm = 1'b1; in_imm = imm; in_dest = dest;
    in_a = '1; in_b = '1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, out_result, exp_r);
    chk({req, " wr"}, {63'd0, out_wr}, {63'd0, exp_wr});
    chk({req, " cc"}, {56'd0, out_cc}, {56'd0, exp_cc});
  endtask

  task automatic t_setup;
    setup("R8 full imm", 22'h3F_FFFF, 5'd3, 64'h0000_0000_FFFF_FC00, 1'b1);
    setup("R8 one", 22'd1, 5'd0, 64'h400, 1'b1);
    setup("R9 nop", 22'd0, 5'd0, 64'd0, 1'b0);
    setup("R9 zero imm nonzero dest", 22'd0, 5'd5, 64'd0, 1'b1);
  endtask

  task automatic immop(input string req, input logic [1:0] form, input logic [21:0] imm,
                       input logic [63:0] exp_r);
    @(negedge clk);
    in_op = 4'd0; in_set_cc = 1'b0; in_use_imm = 1'b1; in_imm_form = form; in_imm = imm;
    in_a = 64'd0; in_b = 64'h5555; in_dest = 5'd1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_use_imm = 1'b0;
    chk(req, out_result, exp_r);
  endtask

  task automatic t_imm;
    immop("R10 form13 neg", 2'd0, 22'h1000, 64'hFFFF_FFFF_FFFF_F000);
    immop("R10 form13 pos", 2'd0, 22'h0FFF, 64'h0FFF);
    immop("R10 form11 neg", 2'd1, 22'h0400, 64'hFFFF_FFFF_FFFF_FC00);
    immop("R10 form10 neg", 2'd2, 22'h0200, 64'hFFFF_FFFF_FFFF_FE00);
    immop("R10 form10 upper ignored", 2'd2, 22'h10FF, 64'h00FF);
    immop("R10 form3 as 13", 2'd3, 22'h3F_1FFF, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_stall;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    chk("R11 drained", {63'd0, out_valid}, 64'd0);
    out_ready = 1'b0;
    in_op = 4'd0; in_set_cc = 1'b0; in_use_imm = 1'b0; in_a = 64'd40; in_b = 64'd2;
    in_dest = 5'd9; in_valid = 1'b1;
    @(negedge clk);
    chk("R12 first out", out_result, 64'd42);
    in_a = 64'd100; in_b = 64'd1; in_dest = 5'd10;
    chk("R11 not ready", {63'd0, in_ready}, 64'd0);
    repeat (3) @(negedge clk);
    chk("R11 held result", out_result, 64'd42);
    chk("R11 held dest", {59'd0, out_dest}, 64'd9);
    chk("R11 held valid", {63'd0, out_valid}, 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 second out", out_result, 64'd101);
    chk("R11 second dest", {59'd0, out_dest}, 64'd10);
    @(negedge clk);
    chk("R11 empty after drain", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_carry_in();
    t_logic();
    t_nocc();
    t_setup();
    t_imm();
    t_stall();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule